// File: doc/BRIEF.md
# Interrupt Recognition and Entry Controller

This block decides when a CPU may take an interrupt, which one it takes, and in what order the entry steps run. It watches an active-low external interrupt pin, a vector of peripheral requests, a software-interrupt decode from the instruction stream and the CPU's hardware interrupt mask. It only accepts a request on a cycle in which the CPU marks an instruction boundary. After accepting a request it asks for the CPU context to be saved and waits for a done handshake. It then commands the mask to be set and presents the vector address of the chosen source together with a one-cycle acknowledge to that source.

The controller is a four-state machine. `ST_IDLE` waits for a boundary with an eligible request (transition *accept*). `ST_STACK` holds the save request until `stack_done` (transition *saved*). `ST_MASK` lasts one cycle and raises `set_mask` (transition *masked*). `ST_VECTOR` lasts one cycle, presents the vector and acknowledges the source (transition *fetched*), and the machine then returns to `ST_IDLE`. The pin can be qualified either as a low level or as a falling edge that is held until it is acknowledged. An internal hold keeps hardware requests blocked from the mask step until the CPU reports its mask as set, which closes the gap before the CPU's own mask bit changes.

Top module: `irq_entry_ctrl`

## Requirements
- R1: With `irq_edge_mode`=0 the pin request is pending whenever `irq_n` is 0. It stays pending after an acknowledge while the pin is still low, and it is not pending once the pin is 1.
- R2: With `irq_edge_mode`=1 a 1-to-0 change of `irq_n` latches a pin request that persists after the pin returns high. The latch is cleared by `irq_ack`, and a pin held low produces no further request.
- R3: While `mask_i`=1, pin and peripheral requests are not accepted.
- R4: `swi_req` is accepted whatever the value of `mask_i`.
- R5: A request is accepted only on a cycle with `insn_done`=1 while the controller is idle. `stack_req` rises on the following cycle.
- R6: Entry runs in this order. `stack_req` stays high until a cycle with `stack_done`=1. The next cycle has `set_mask`=1 for one cycle. The cycle after that has `vec_valid`=1 and the source acknowledge for one cycle, and then the controller is idle.
- R7: Among eligible requests the order is: software interrupt, then the pin, then peripheral 0, 1, and so on. At most one acknowledge is high in any cycle.
- R8: The source number is 0 for the software interrupt, 1 for the pin and 2+i for peripheral i. `vec_addr` equals 2^ADDR_W − 4 − 2·source while `vec_valid`=1 (0xFFFC, 0xFFFA, 0xFFF8 − 2i for 16 bits), and is 0 otherwise.
- R9: After `set_mask`, hardware requests stay blocked even while `mask_i`=0, until `mask_i` has been seen at 1. After that only `mask_i` gates them.
- R10: While `rst_n`=0 all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_n | input | 1 | External interrupt pin, active low |
| irq_edge_mode | input | 1 | 1 = falling edge, 0 = low level |
| swi_req | input | 1 | Software interrupt decoded, held until acknowledged |
| periph_req | input | NUM_PERIPH | Peripheral requests, level |
| mask_i | input | 1 | CPU hardware interrupt mask bit |
| insn_done | input | 1 | Instruction boundary strobe |
| stack_done | input | 1 | Context save finished |
| stack_req | output | 1 | Context save request |
| set_mask | output | 1 | Command to set the CPU mask bit |
| vec_valid | output | 1 | Vector fetch cycle |
| vec_addr | output | ADDR_W | Vector address of the taken source |
| swi_ack | output | 1 | Software interrupt acknowledge |
| irq_ack | output | 1 | Pin interrupt acknowledge |
| periph_ack | output | NUM_PERIPH | Peripheral acknowledges |

## Verification
Several properties are checked by assertions on every cycle. They cover the step order (save, then mask, then vector), the holding of the save request, acceptance only on a boundary strobe, that a masked or held-off entry can only be the software interrupt, the single acknowledge, and the clearing of the edge latch on acknowledge. Other behaviour can only be shown by the bench's scenarios against its cycle model. These are the choice of winner among simultaneous requests, the vector address values, the re-taking of a level request still held low, the non-retriggering of an edge held low, and the release of the nested hold once the mask has been set and then cleared.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STACK,
        ST_MASK,
        ST_VECTOR
    } entry_state_e;

endpackage

// File: rtl/irq_pin_detect.sv
module irq_pin_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic edge_mode,
    input  logic ack,
    output logic pending
);

    logic irq_prev;
    logic edge_latch;
    logic fall_seen;

    assign fall_seen = edge_mode && irq_prev && !irq_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_prev   <= 1'b1;
            edge_latch <= 1'b0;
        end else begin
            irq_prev <= irq_n;
            if (fall_seen)
                edge_latch <= 1'b1;
            else if (ack)
                edge_latch <= 1'b0;
        end
    end

    assign pending = edge_mode ? edge_latch : !irq_n;

    // R2
    edge_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !fall_seen) |=> !edge_latch);

endmodule

// File: rtl/irq_prio_select.sv
module irq_prio_select #(
    parameter int NUM_PERIPH = 4,
    parameter int SRC_W      = $clog2(NUM_PERIPH + 2)
) (
    input  logic                  swi_req,
    input  logic                  irq_pend,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic                  hw_en,
    output logic                  hit,
    output logic [SRC_W-1:0]      src
);

    always_comb begin
        hit = 1'b0;
        src = '0;
        for (int i = NUM_PERIPH - 1; i >= 0; i--) begin
            if (hw_en && periph_req[i]) begin
                hit = 1'b1;
                src = SRC_W'(i + 2);
            end
        end
        if (hw_en && irq_pend) begin
            hit = 1'b1;
            src = SRC_W'(1);
        end
        if (swi_req) begin
            hit = 1'b1;
            src = '0;
        end
    end

endmodule

// File: rtl/irq_entry_ctrl.sv
module irq_entry_ctrl
    import irq_entry_pkg::*;
#(
    parameter int NUM_PERIPH = 4,
    parameter int ADDR_W     = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  irq_n,
    input  logic                  irq_edge_mode,
    input  logic                  swi_req,
    input  logic [NUM_PERIPH-1:0] periph_req,
    input  logic                  mask_i,
    input  logic                  insn_done,
    input  logic                  stack_done,
    output logic                  stack_req,
    output logic                  set_mask,
    output logic                  vec_valid,
    output logic [ADDR_W-1:0]     vec_addr,
    output logic                  swi_ack,
    output logic                  irq_ack,
    output logic [NUM_PERIPH-1:0] periph_ack
);

    localparam int SRC_W = $clog2(NUM_PERIPH + 2);

    entry_state_e     state_q, state_d;
    logic [SRC_W-1:0] src_q, src_pick;
    logic             pick_hit;
    logic             irq_pend;
    logic             mask_hold;
    logic             hw_en;

    assign hw_en = !(mask_i || mask_hold);

    irq_pin_detect u_pin (
        .clk       (clk),
        .rst_n     (rst_n),
        .irq_n     (irq_n),
        .edge_mode (irq_edge_mode),
        .ack       (irq_ack),
        .pending   (irq_pend)
    );

    irq_prio_select #(
        .NUM_PERIPH (NUM_PERIPH),
        .SRC_W      (SRC_W)
    ) u_prio (
        .swi_req    (swi_req),
        .irq_pend   (irq_pend),
        .periph_req (periph_req),
        .hw_en      (hw_en),
        .hit        (pick_hit),
        .src        (src_pick)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            src_q     <= '0;
            mask_hold <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && state_d == ST_STACK)
                src_q <= src_pick;
            if (state_q == ST_MASK)
                mask_hold <= 1'b1;
            else if (mask_i)
                mask_hold <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (insn_done && pick_hit) state_d = ST_STACK;
            ST_STACK:  if (stack_done) state_d = ST_MASK;
            ST_MASK:   state_d = ST_VECTOR;
            ST_VECTOR: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        stack_req = (state_q == ST_STACK);
        set_mask  = (state_q == ST_MASK);
        vec_valid = (state_q == ST_VECTOR);
        vec_addr  = vec_valid
                  ? (ADDR_W'(0) - ADDR_W'(4) - (ADDR_W'(src_q) << 1))
                  : '0;
        swi_ack   = vec_valid && (src_q == SRC_W'(0));
        irq_ack   = vec_valid && (src_q == SRC_W'(1));
    end

    for (genvar g = 0; g < NUM_PERIPH; g++) begin : g_ack
        assign periph_ack[g] = vec_valid && (src_q == SRC_W'(g + 2));
    end

    // R6
    mask_after_stack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_mask |-> $past(stack_req && stack_done));

    // R6
    vector_after_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(set_mask));

    // R6
    stack_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stack_req && !stack_done) |=> stack_req);

    // R5
    entry_on_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stack_req) |-> $past(insn_done));

    // R3
    masked_hw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stack_req) && $past(mask_i)) |-> (src_q == '0));

    // R9
    nested_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(stack_req) && $past(mask_hold)) |-> (src_q == '0));

    // R7
    one_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({swi_ack, irq_ack, periph_ack}));

endmodule

// File: tb/irq_entry_ctrl_test.sv
module irq_entry_ctrl_test;

    localparam int NP     = 4;
    localparam int AW     = 16;
    localparam time TCLK  = 8ns;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          irq_n = 1'b1;
    logic          irq_edge_mode = 1'b0;
    logic          swi_req = 1'b0;
    logic [NP-1:0] periph_req = '0;
    logic          mask_i = 1'b0;
    logic          insn_done = 1'b0;
    logic          stack_done = 1'b0;
    logic          stack_req, set_mask, vec_valid, swi_ack, irq_ack;
    logic [AW-1:0] vec_addr;
    logic [NP-1:0] periph_ack;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit insn_en = 1;
    bit auto_mask = 1;
    int stack_delay = 1;
    int icnt = 0;
    int scnt = 0;

    // reference model state
    int m_st = 0, m_sel = 0;
    bit m_edge = 0, m_prev = 1, m_shadow = 0;

    always #(TCLK/2) clk = ~clk;

    irq_entry_ctrl #(.NUM_PERIPH(NP), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .irq_edge_mode(irq_edge_mode),
        .swi_req(swi_req), .periph_req(periph_req), .mask_i(mask_i),
        .insn_done(insn_done), .stack_done(stack_done), .stack_req(stack_req),
        .set_mask(set_mask), .vec_valid(vec_valid), .vec_addr(vec_addr),
        .swi_ack(swi_ack), .irq_ack(irq_ack), .periph_ack(periph_ack)
    );

    function automatic int vec_of(int s);
        return (1 << AW) - 4 - 2 * s;
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural cycle model
    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_sel = 0; m_edge = 0; m_prev = 1; m_shadow = 0;
        end else begin
            bit pend, eff, hit, n_edge, n_shadow;
            int nsel;
            pend = irq_edge_mode ? m_edge : !irq_n;
            eff  = mask_i || m_shadow;
            hit  = 0; nsel = 0;
            if (swi_req) begin hit = 1; nsel = 0; end
            else if (!eff && pend) begin hit = 1; nsel = 1; end
            else if (!eff) begin
                for (int i = 0; i < NP; i++)
                    if (!hit && periph_req[i]) begin hit = 1; nsel = i + 2; end
            end
            n_edge = m_edge;
            if (m_st == 3 && m_sel == 1) n_edge = 0;
            if (irq_edge_mode && m_prev && !irq_n) n_edge = 1;
            n_shadow = (m_st == 2) ? 1'b1 : (mask_i ? 1'b0 : m_shadow);
            case (m_st)
                0: if (insn_done && hit) begin m_st = 1; m_sel = nsel; end
                1: if (stack_done) m_st = 2;
                2: m_st = 3;
                default: m_st = 0;
            endcase
            m_edge = n_edge; m_shadow = n_shadow; m_prev = irq_n;
        end
    end

    // compare every cycle
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk(stack_req == (m_st == 1), "R6 stack_req", stack_req, m_st == 1);
            chk(set_mask == (m_st == 2), "R6 set_mask", set_mask, m_st == 2);
            chk(vec_valid == (m_st == 3), "R6 vec_valid", vec_valid, m_st == 3);
            chk(int'(vec_addr) == ((m_st == 3) ? vec_of(m_sel) : 0), "R8 vec_addr",
                vec_addr, (m_st == 3) ? vec_of(m_sel) : 0);
            chk(swi_ack == (m_st == 3 && m_sel == 0), "R7 swi_ack", swi_ack, 0);
            chk(irq_ack == (m_st == 3 && m_sel == 1), "R1 R2 irq_ack", irq_ack, 0);
            for (int i = 0; i < NP; i++)
                chk(periph_ack[i] == (m_st == 3 && m_sel == i + 2), "R7 periph_ack",
                    periph_ack[i], 0);
        end
    end

    // CPU and source responders
    always @(negedge clk) begin
        if (insn_en) begin
            icnt++;
            insn_done = (icnt % 3 == 0);
        end else insn_done = 0;
        if (stack_req) scnt++; else scnt = 0;
        stack_done = stack_req && (scnt > stack_delay);
        if (auto_mask && set_mask) mask_i = 1;
        if (swi_ack) swi_req = 0;
        for (int i = 0; i < NP; i++)
            if (periph_ack[i]) periph_req[i] = 0;
    end

    task automatic wait_entry(input int exp_src, input string tag);
        int src;
        bit seen;
        seen = 0;
        for (int k = 0; k < 60 && !seen; k++) begin
            @(negedge clk);
            if (vec_valid) seen = 1;
        end
        src = -1;
        if (swi_ack) src = 0;
        else if (irq_ack) src = 1;
        else for (int i = 0; i < NP; i++) if (periph_ack[i]) src = i + 2;
        chk(seen, {tag, " entry taken"}, seen, 1);
        chk(src == exp_src, {tag, " source"}, src, exp_src);
        chk(int'(vec_addr) == vec_of(exp_src), "R8 vector", vec_addr, vec_of(exp_src));
    endtask

    task automatic no_entry(input int n, input string tag);
        bit any;
        any = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (stack_req) any = 1;
        end
        chk(!any, {tag, " no entry"}, any, 0);
    endtask

    task automatic release_mask();
        @(negedge clk);
        mask_i = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        chk({stack_req, set_mask, vec_valid, swi_ack, irq_ack} == 5'b0 && periph_ack == '0
            && vec_addr == '0, "R10 reset outputs", stack_req, 0);
        rst_n = 1;
        repeat (3) @(negedge clk);

        // R1 level mode
        irq_n = 0;
        wait_entry(1, "R1");
        no_entry(9, "R3");
        release_mask();
        wait_entry(1, "R1 still low");
        @(negedge clk); irq_n = 1;
        release_mask();
        no_entry(12, "R1");

        // R2 edge mode
        irq_edge_mode = 1;
        @(negedge clk); irq_n = 0;
        @(negedge clk); irq_n = 1;
        wait_entry(1, "R2");
        release_mask();
        no_entry(12, "R2 cleared");
        @(negedge clk); irq_n = 0;
        wait_entry(1, "R2 held");
        release_mask();
        no_entry(12, "R2 held low");
        @(negedge clk); irq_n = 1; irq_edge_mode = 0;

        // R3 / R4 masked behaviour
        @(negedge clk); mask_i = 1; periph_req[2] = 1;
        no_entry(12, "R3");
        @(negedge clk); swi_req = 1;
        wait_entry(0, "R4");
        release_mask();
        wait_entry(4, "R3 after unmask");
        release_mask();

        // R5 boundary, R7 priority
        @(negedge clk); insn_en = 0;
        swi_req = 1; irq_n = 0; periph_req[1] = 1; periph_req[3] = 1;
        no_entry(10, "R5");
        @(negedge clk); insn_en = 1;
        wait_entry(0, "R7 swi first");
        release_mask();
        wait_entry(1, "R7 pin second");
        @(negedge clk); irq_n = 1;
        release_mask();
        wait_entry(3, "R7 periph1");
        release_mask();
        wait_entry(5, "R7 periph3");
        release_mask();

        // R9 nested hold
        @(negedge clk); auto_mask = 0; periph_req[0] = 1;
        wait_entry(2, "R9 first");
        @(negedge clk); periph_req[3] = 1;
        no_entry(12, "R9 held");
        @(negedge clk); mask_i = 1;
        @(negedge clk); mask_i = 0;
        wait_entry(5, "R9 released");
        @(negedge clk); auto_mask = 1; mask_i = 1;
        release_mask();

        // R6 long save
        @(negedge clk); stack_delay = 6; swi_req = 1;
        wait_entry(0, "R6 long save");
        release_mask();
        repeat (5) @(negedge clk);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(TCLK * 150000);
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule